// File: doc/BRIEF.md
# Fractional Carrier Offset Derotator

This block removes the fractional carrier frequency offset from a received complex baseband stream. At frame detection the synchroniser hands over its autocorrelation result P together with a load strobe. The block measures the angle of P with a vectoring CORDIC and divides it by the preamble period L. Because L is always a power of two, the division is an arithmetic right shift, and the shift amount is chosen at runtime. The result is the per-sample phase step. Each accepted sample is then rotated backwards by a running phase that grows by one step per sample. A tone that carries a residual offset therefore leaves the block with a steady phase.

Samples enter on a valid/ready slave port and leave on a valid/ready master port through one output register. The slave side is ready when that register is empty or is being drained in the same cycle, and it is never ready while the load strobe is high. While the master side stalls (valid high, ready low), the output word and its valid flag hold. Phase advances only on samples that are accepted, so stalls and gaps never distort the correction. The estimate is taken from the current burst only. Every load restarts the running phase, and the first sample accepted after a load is rotated by zero.

Phase is kept as an unsigned fraction of a full turn, with 16 bits for the angle. The accumulator carries extra low bits so that the shift does not discard precision. Both CORDICs are unrolled, so the angle is latched on the edge that sees the load strobe, and a rotated sample appears one cycle after it is accepted.

Top module: `cfo_derotator`

## Requirements
- R1: `s_ready` is high exactly when the output register is empty or `m_ready` is high, and `load` is low. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_re` and `m_im` hold their values.
- R2: A sample accepted on a rising edge (`s_valid` and `s_ready` both high) is presented with `m_valid` high after that same edge, a latency of one cycle. If an output is taken and no new sample is accepted, `m_valid` falls after that edge.
- R3: `p_re`, `p_im` and `shift_sel` are sampled only on an edge where `load` is high. At all other times they have no effect on the output. No sample is accepted in a load cycle.
- R4: The first sample accepted after a load is passed with zero rotation. Its output angle equals its input angle to within 0.5 degrees.
- R5: With θ as the angle of P, k as the latched `shift_sel` and d as the count of samples accepted since the load (starting at 0), the output is the input multiplied by e^{-j·d·θ/2^k}. For a tone whose offset per sample is θ/2^k, with k from 3 to 6 and |P| near 30000, the output phase stays within 5 degrees of the tone's initial phase over 1024 samples.
- R6: The CORDIC gain is compensated, so the output magnitude stays within 2 % of the input magnitude for inputs of magnitude 8000.
- R7: After reset, `m_valid` is low, `s_ready` is high and the phase step is zero. Samples then pass unrotated to within 4 LSB per component.
- R8: The running phase advances once per accepted sample, not once per clock. Gaps in `s_valid` and stalls on `m_ready` leave the R5 bound intact.
- R9: Output components saturate symmetrically to ±(2^(W-1)-1). The most negative code never appears on `m_re` or `m_im`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Latch a new correlation value and shift amount; restarts the phase |
| p_re | input | W | Real part of the correlation value P, signed |
| p_im | input | W | Imaginary part of P, signed |
| shift_sel | input | SH_W | log2 of the preamble period L |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted on this edge when valid |
| s_re | input | W | Input sample real part, signed |
| s_im | input | W | Input sample imaginary part, signed |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream accepts the output sample |
| m_re | output | W | Derotated real part, signed |
| m_im | output | W | Derotated imaginary part, signed |

## Verification
The main check drives offset-bearing tones into the block. The tones differ in offset angle, in all four quadrants and in both signs, in shift amount and in starting phase. Each tone is measured by the worst phase drift and the magnitude spread over 1024 outputs. A wrong sign, a wrong shift or a wrong CORDIC quadrant shows up as drift, and missing gain compensation shows up as a magnitude error. Two of the tones are streamed with gaps on the input and stalls on the output, which separates advancing the phase per accepted sample from advancing it per clock. Directed patterns cover the rest: full-scale inputs for the clamp, a P that changes without a load, and back-pressure to check that held outputs stay fixed.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
  // phase is an unsigned fraction of one turn
  localparam int ANG_W = 16;

  // atan(2^-i) expressed in 1/65536 of a turn
  function automatic logic [ANG_W-1:0] atan_turn(input int i);
    case (i)
      0:  return 16'd8192;
      1:  return 16'd4836;
      2:  return 16'd2555;
      3:  return 16'd1297;
      4:  return 16'd651;
      5:  return 16'd326;
      6:  return 16'd163;
      7:  return 16'd81;
      8:  return 16'd41;
      9:  return 16'd20;
      10: return 16'd10;
      11: return 16'd5;
      12: return 16'd3;
      13: return 16'd1;
      14: return 16'd1;
      default: return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/cfo_angle_vec.sv
// Vectoring CORDIC: angle of (re, im) as a fraction of a turn.
module cfo_angle_vec #(
  parameter int W    = 16,
  parameter int ITER = 15
) (
  input  logic signed [W-1:0]             re,
  input  logic signed [W-1:0]             im,
  output logic [cfo_pkg::ANG_W-1:0]       ang
);
  localparam int XW = W + 2;

  always_comb begin
    logic signed [XW-1:0] x, y, xn;
    logic [cfo_pkg::ANG_W-1:0] z;
    // fold the left half plane onto the right one
    if (re[W-1]) begin
      x = -XW'(re);
      y = -XW'(im);
      z = 16'h8000;
    end else begin
      x = XW'(re);
      y = XW'(im);
      z = '0;
    end
    for (int i = 0; i < ITER; i++) begin
      if (!y[XW-1]) begin
        xn = x + (y >>> i);
        y  = y - (x >>> i);
        z  = z + cfo_pkg::atan_turn(i);
      end else begin
        xn = x - (y >>> i);
        y  = y + (x >>> i);
        z  = z - cfo_pkg::atan_turn(i);
      end
      x = xn;
    end
    ang = z;
  end
endmodule

// File: rtl/cfo_rotator.sv
// Rotation CORDIC with gain compensation and symmetric clamp (R6, R9).
module cfo_rotator #(
  parameter int W    = 16,
  parameter int ITER = 15
) (
  input  logic signed [W-1:0]       re,
  input  logic signed [W-1:0]       im,
  input  logic [cfo_pkg::ANG_W-1:0] ang,
  output logic signed [W-1:0]       o_re,
  output logic signed [W-1:0]       o_im
);
  localparam int XW = W + 2;
  localparam int PW = XW + 17;
  localparam logic signed [PW-1:0] GC   = PW'(19898);          // 1/K in Q15
  localparam logic signed [PW-1:0] RND  = PW'(16384);
  localparam logic signed [PW-1:0] MAXV = PW'((1 <<< (W-1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV;

  function automatic logic signed [W-1:0] clip(input logic signed [PW-1:0] v);
    if (v > MAXV)      return W'(MAXV);
    else if (v < MINV) return W'(MINV);
    else               return W'(v);
  endfunction

  logic signed [XW-1:0] xr, yr;

  always_comb begin
    logic signed [XW-1:0] x, y, xn;
    logic [cfo_pkg::ANG_W-1:0] z;
    z = ang;
    if (z[15] != z[14]) begin
      // beyond a quarter turn: rotate by a half turn first
      x = -XW'(re);
      y = -XW'(im);
      z = z + 16'h8000;
    end else begin
      x = XW'(re);
      y = XW'(im);
    end
    for (int i = 0; i < ITER; i++) begin
      if (!z[15]) begin
        xn = x - (y >>> i);
        y  = y + (x >>> i);
        z  = z - cfo_pkg::atan_turn(i);
      end else begin
        xn = x + (y >>> i);
        y  = y - (x >>> i);
        z  = z + cfo_pkg::atan_turn(i);
      end
      x = xn;
    end
    xr = x;
    yr = y;
  end

  logic signed [PW-1:0] pr, pi;
  always_comb begin
    pr   = (PW'(xr) * GC + RND) >>> 15;
    pi   = (PW'(yr) * GC + RND) >>> 15;
    o_re = clip(pr);
    o_im = clip(pi);
  end
endmodule

// File: rtl/cfo_derotator.sv
module cfo_derotator #(
  parameter int W    = 16,
  parameter int ITER = 15,
  parameter int SH_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic signed [W-1:0] p_re,
  input  logic signed [W-1:0] p_im,
  input  logic [SH_W-1:0]     shift_sel,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic signed [W-1:0] s_re,
  input  logic signed [W-1:0] s_im,
  output logic                m_valid,
  input  logic                m_ready,
  output logic signed [W-1:0] m_re,
  output logic signed [W-1:0] m_im
);
  localparam int ANG_W  = cfo_pkg::ANG_W;
  localparam int MAX_SH = (1 << SH_W) - 1;
  localparam int ACC_W  = ANG_W + MAX_SH;

  logic [ANG_W-1:0]        ang_p, theta_q, phase_use, rot_ang;
  logic [SH_W-1:0]         sh_q;
  logic [ACC_W-1:0]        acc_q, acc_use;
  logic signed [ACC_W-1:0] step_full;
  logic                    fresh_q, accept;
  logic signed [W-1:0]     rot_re, rot_im;

  cfo_angle_vec #(.W(W), .ITER(ITER)) u_vec (
    .re(p_re), .im(p_im), .ang(ang_p)
  );

  // R5: angle / 2^k by arithmetic shift; low bits keep the fraction
  assign step_full = $signed({theta_q, {MAX_SH{1'b0}}}) >>> sh_q;
  // R4: first sample after a load uses zero phase
  assign acc_use   = fresh_q ? '0 : acc_q;
  assign phase_use = acc_use[ACC_W-1 -: ANG_W];
  assign rot_ang   = ANG_W'(0) - phase_use;

  cfo_rotator #(.W(W), .ITER(ITER)) u_rot (
    .re(s_re), .im(s_im), .ang(rot_ang), .o_re(rot_re), .o_im(rot_im)
  );

  // R1, R3: handshake rule
  assign s_ready = (!m_valid || m_ready) && !load;
  assign accept  = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      theta_q <= '0;
      sh_q    <= '0;
      acc_q   <= '0;
      fresh_q <= 1'b1;
      m_valid <= 1'b0;
      m_re    <= '0;
      m_im    <= '0;
    end else begin
      if (load) begin
        theta_q <= ang_p;
        sh_q    <= shift_sel;
        fresh_q <= 1'b1;
      end else if (accept) begin
        // R8: phase moves only with accepted samples
        acc_q   <= acc_use + $unsigned(step_full);
        fresh_q <= 1'b0;
      end
      if (accept) begin
        m_valid <= 1'b1;
        m_re    <= rot_re;
        m_im    <= rot_im;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfo_derotator_chk.sv
module cfo_derotator_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                load,
  input logic                s_valid,
  input logic                s_ready,
  input logic                m_valid,
  input logic                m_ready,
  input logic signed [W-1:0] m_re,
  input logic signed [W-1:0] m_im
);
  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_re) && $stable(m_im)));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);

  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !(s_valid && s_ready)) |=> !m_valid);

  p_no_accept_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !s_ready);

  p_no_most_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_re != MOST_NEG && m_im != MOST_NEG));
endmodule

bind cfo_derotator cfo_derotator_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_re(m_re), .m_im(m_im)
);

// File: tb/cfo_derotator_bench.sv
`timescale 1ns/1ps
module cfo_derotator_bench;
  localparam int  W   = 16;
  localparam int  NS  = 1024;
  localparam real D2R = 3.14159265358979 / 180.0;

  // stimulus table: P angle (deg), shift, tone start phase (deg), gappy flow
  localparam int NV = 5;
  localparam int V_DEG [NV] = '{100, -150, 40, 170, -60};
  localparam int V_SH  [NV] = '{4, 5, 3, 6, 4};
  localparam int V_PSI [NV] = '{20, -70, 135, -160, 0};
  localparam int V_GAP [NV] = '{0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic signed [W-1:0] p_re = '0, p_im = '0, s_re = '0, s_im = '0;
  logic [2:0] shift_sel = '0;
  logic s_valid = 1'b0, m_ready = 1'b1;
  logic s_ready, m_valid;
  logic signed [W-1:0] m_re, m_im;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cfo_derotator u_cfo_derotator (
    .clk(clk), .rst_n(rst_n), .load(load), .p_re(p_re), .p_im(p_im),
    .shift_sel(shift_sel), .s_valid(s_valid), .s_ready(s_ready),
    .s_re(s_re), .s_im(s_im), .m_valid(m_valid), .m_ready(m_ready),
    .m_re(m_re), .m_im(m_im)
  );

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic real ang_deg(input int re, input int im);
    return $atan2(real'(im), real'(re)) / D2R;
  endfunction

  function automatic real wrap(input real a);
    real r;
    r = a;
    while (r > 180.0)   r = r - 360.0;
    while (r <= -180.0) r = r + 360.0;
    return r;
  endfunction

  function automatic real fabs(input real a);
    return (a < 0.0) ? -a : a;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int vi);
    real pd, fs, psi, ph, err, maxerr, mag, magmin, magmax;
    int  k, d, j, cyc;
    bit  gap;
    string rq;
    pd  = real'(V_DEG[vi]);
    k   = V_SH[vi];
    psi = real'(V_PSI[vi]);
    gap = (V_GAP[vi] != 0);
    rq  = gap ? "R8" : "R5";
    fs  = pd / (2.0 ** k);
    @(negedge clk);
    p_re = W'(rnd(30000.0 * $cos(pd * D2R)));
    p_im = W'(rnd(30000.0 * $sin(pd * D2R)));
    shift_sel = 3'(k);
    load = 1'b1;
    s_valid = 1'b0;
    m_ready = 1'b1;
    @(negedge clk);
    load = 1'b0;
    // R3: new values without a load must be ignored
    shift_sel = 3'(7 - k);
    p_re = '0;
    p_im = W'(12345);
    d = 0; j = 0; cyc = 0;
    maxerr = 0.0; magmin = 1.0e9; magmax = 0.0;
    while (j < NS && cyc < 20000) begin
      m_ready = gap ? ((cyc % 7) != 3) : 1'b1;
      s_valid = (d < NS) && (gap ? ((cyc % 5) != 2) : 1'b1);
      ph   = (psi + fs * real'(d)) * D2R;
      s_re = W'(rnd(8000.0 * $cos(ph)));
      s_im = W'(rnd(8000.0 * $sin(ph)));
      #1;
      if (m_valid && m_ready) begin
        err = fabs(wrap(ang_deg(int'(m_re), int'(m_im)) - psi));
        if (j == 0) chk(err <= 0.5, "R4", "first output phase error (deg)", err, 0.0);
        if (err > maxerr) maxerr = err;
        mag = $sqrt(real'(m_re) * real'(m_re) + real'(m_im) * real'(m_im));
        if (mag < magmin) magmin = mag;
        if (mag > magmax) magmax = mag;
        j++;
      end
      if (s_valid && s_ready) d++;
      cyc++;
      @(negedge clk);
    end
    s_valid = 1'b0;
    m_ready = 1'b1;
    chk(j == NS, rq, "outputs collected", real'(j), real'(NS));
    chk(maxerr <= 5.0, rq, "max residual phase drift (deg)", maxerr, 5.0);
    chk(magmin >= 7840.0 && magmax <= 8160.0, "R6", "magnitude min/max",
        (magmin < 7840.0) ? magmin : magmax, 8000.0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    real maxerr, err;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(m_valid == 1'b0, "R7", "m_valid after reset", real'(m_valid), 0.0);
    chk(s_ready == 1'b1, "R7", "s_ready after reset", real'(s_ready), 1.0);

    // table walk
    for (int vi = 0; vi < NV; vi++) run_vec(vi);

    // directed: reset again
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; load = 1'b0; m_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(m_valid == 1'b0, "R7", "m_valid after second reset", real'(m_valid), 0.0);

    // pass-through with zero step, one-cycle latency
    @(negedge clk);
    s_re = W'(3000); s_im = W'(-2000); s_valid = 1'b1;
    @(negedge clk);
    chk(m_valid == 1'b1, "R2", "m_valid one cycle after accept", real'(m_valid), 1.0);
    chk(fabs(real'(m_re) - 3000.0) <= 4.0 && fabs(real'(m_im) + 2000.0) <= 4.0,
        "R7", "unrotated pass-through re", real'(m_re), 3000.0);
    s_valid = 1'b0;
    @(negedge clk);
    chk(m_valid == 1'b0, "R2", "m_valid after drain", real'(m_valid), 0.0);

    // back-pressure
    m_ready = 1'b0;
    s_re = W'(5000); s_im = W'(1000); s_valid = 1'b1;
    @(negedge clk);
    #1;
    chk(s_ready == 1'b0, "R1", "s_ready while stalled", real'(s_ready), 0.0);
    s_re = W'(-4000); s_im = W'(2500);
    repeat (3) @(negedge clk);
    chk(m_valid == 1'b1 && fabs(real'(m_re) - 5000.0) <= 4.0, "R1",
        "held output re", real'(m_re), 5000.0);
    m_ready = 1'b1;
    @(negedge clk);
    chk(fabs(real'(m_re) + 4000.0) <= 4.0 && fabs(real'(m_im) - 2500.0) <= 4.0,
        "R1", "next output after release re", real'(m_re), -4000.0);
    s_valid = 1'b0;
    @(negedge clk);

    // load blocks acceptance, then zero-phase first sample
    s_re = W'(-6000); s_im = W'(-3000); s_valid = 1'b1;
    p_re = W'(30000); p_im = '0; shift_sel = 3'd4; load = 1'b1;
    #1;
    chk(s_ready == 1'b0, "R3", "s_ready during load", real'(s_ready), 1'b0);
    @(negedge clk);
    load = 1'b0;
    chk(m_valid == 1'b0, "R3", "nothing accepted in load cycle", real'(m_valid), 0.0);
    @(negedge clk);
    chk(fabs(real'(m_re) + 6000.0) <= 4.0 && fabs(real'(m_im) + 3000.0) <= 4.0,
        "R4", "first sample after load re", real'(m_re), -6000.0);
    s_valid = 1'b0;
    @(negedge clk);

    // saturation
    s_re = W'(32767); s_im = W'(32767); s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk(m_re >= W'(32700) && m_im >= W'(32700), "R9", "positive full scale re",
        real'(m_re), 32767.0);
    @(negedge clk);
    s_re = W'(-32768); s_im = W'(-32768); s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk(m_re >= -W'(32767) && m_re <= -W'(32700) && m_im >= -W'(32767),
        "R9", "negative full scale re", real'(m_re), -32767.0);
    @(negedge clk);

    // P and shift changed without a load: step stays near zero
    p_re = '0; p_im = W'(30000); shift_sel = 3'd0;
    maxerr = 0.0;
    for (int i = 0; i < 17; i++) begin
      s_valid = (i < 16);
      s_re = W'(8000); s_im = '0;
      #1;
      if (m_valid) begin
        err = fabs(ang_deg(int'(m_re), int'(m_im)));
        if (err > maxerr) maxerr = err;
      end
      @(negedge clk);
    end
    s_valid = 1'b0;
    chk(maxerr <= 1.0, "R3", "phase error with unloaded P (deg)", maxerr, 0.0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule